// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block sits beside a small 8-bit processor core and decides which of six interrupt sources the core should service next. The sources are two external request pins, two timer overflow events, a serial port (receive or transmit flag) and a third timer (overflow or external-capture flag). Software writes a byte-wide enable register and a byte-wide priority register through a one-cycle write strobe. The controller keeps a pending flag for each source, masks it with the enables, sorts the survivors into a high and a low priority group and picks the winner with a fixed polling order.

The winner is held and shown to the core as a request line plus a fixed 16-bit vector address. When the core signals an instruction boundary while the request is up, the controller accepts the request. It pulses an acknowledge for one cycle and marks the priority level of the accepted source as in service. The acknowledge clears the flag of the accepted source when that source is hardware-cleared. A low-priority handler can be preempted by a high-priority request. A high-priority handler cannot be preempted. A return strobe from the core releases the most recently entered level.

Top module: `irq_ctl_2lvl`

## Requirements
- R1: After reset `irq_req` and `irq_ack` are 0, `flag_pend` is 0 with both external pins high, and `irq_vec` reads 0000H whenever `irq_req` is 0.
- R2: A write with `reg_sel`=0 loads the enable register: bit 7 is the global enable, bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 5 timer 2, and bit 6 has no effect. A source can raise `irq_req` only while both its own bit and bit 7 are 1. Clearing bit 7 drops a shown request in the cycle after the write.
- R3: Among eligible requests of the same priority, the winner is the lowest-numbered source in the order external 0, timer 0, external 1, timer 1, serial, timer 2 (indices 0 to 5).
- R4: A write with `reg_sel`=1 loads the priority register. Bits 5..0 use the same source positions as the enable register, and 1 means high priority. Any eligible high-priority source wins over every low-priority one. The register resets to 00H.
- R5: The vector for source index i is 0003H + 8*i: 0003H, 000BH, 0013H, 001BH, 0023H, 002BH. Either serial flag gives 0023H, and either timer-2 flag gives 002BH.
- R6: While a low-priority handler is in service, only high-priority sources may request. While a high-priority handler is in service, no source may request.
- R7: A `reti` pulse releases the high in-service level if it is set, otherwise the low one.
- R8: A request is accepted on a clock edge where `irq_req` and `insn_bound` are both 1. In the next cycle `irq_ack` is 1 for exactly one cycle and `irq_req` is 0.
- R9: The acknowledge clears the flag of an accepted external (edge mode) or timer 0/1 source. The serial and timer-2 flags are inputs that the controller never clears.
- R10: `flag_pend` (bit positions as in R2) shows every pending flag whatever the enables are.
- R11: `ext_edge_mode[k]`=1 makes external k set its flag on a falling edge seen after a two-stage synchronizer, three clock edges after the pin falls. With 0, the flag is the synchronized, inverted pin level.
- R12: While `irq_req` stays 1, `irq_vec` does not change, even if a source that polls earlier becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the enable register, 1 the priority register |
| reg_wdata | input | 8 | Register write data |
| ext0_n | input | 1 | External request 0, active low, asynchronous |
| ext1_n | input | 1 | External request 1, active low, asynchronous |
| ext_edge_mode | input | 2 | Per external input: 1 falling-edge, 0 level |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| ser_rx_flag | input | 1 | Serial receive flag level |
| ser_tx_flag | input | 1 | Serial transmit flag level |
| tmr2_ovf_flag | input | 1 | Timer 2 overflow flag level |
| tmr2_ext_flag | input | 1 | Timer 2 external flag level |
| insn_bound | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the shown request |
| irq_ack | output | 1 | One-cycle acceptance pulse |
| flag_pend | output | 6 | Pending flags of the six sources |

## Verification
The bench sweeps every combination of six pending sources under several priority patterns and checks each winner against an order computed on its own. A wrong polling or priority rule would show up there as a wrong vector. Nesting is driven through low, high, double return and release. A controller that released the wrong level on return would block or pass a request that it should not. The bench also checks that timer flags clear on acknowledge while serial and timer-2 flags survive it; a controller that cleared them all would lose a pending serial service. An earlier-polling source arriving while a request is held must not change the vector, and the falling-edge latency must be exactly three edges.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned NUM_SRC   = 6;
  localparam int unsigned SRC_IDX_W = $clog2(NUM_SRC);
  localparam int unsigned VEC_W     = 16;
  localparam int unsigned VEC_BASE  = 3;
  localparam int unsigned VEC_STEP  = 8;
  localparam int unsigned NUM_EXT   = 2;
  localparam int unsigned NUM_TMR   = 2;
  localparam int unsigned NUM_HWCLR = 4;

  typedef enum logic [SRC_IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_TMR2 = 3'd5
  } src_e;

  typedef struct packed {
    logic                 vld;
    logic [SRC_IDX_W-1:0] idx;
  } pick_t;

  // lowest set index wins: this is the fixed polling order
  function automatic pick_t first_set(input logic [NUM_SRC-1:0] m);
    pick_t p;
    p = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (m[i]) begin
        p.vld = 1'b1;
        p.idx = i[SRC_IDX_W-1:0];
      end
    end
    return p;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STEP);
  endfunction
endpackage

// File: rtl/irq_ext_in.sv
module irq_ext_in #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic flag,
  output logic fall_evt
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   edge_flag_q;

  assign fall_evt = prev_q & ~sync_q[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= '1;
      prev_q      <= 1'b1;
      edge_flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= sync_q[TOP];
      if (edge_mode && fall_evt) edge_flag_q <= 1'b1;
      else if (clr || !edge_mode) edge_flag_q <= 1'b0;
    end
  end

  assign flag = edge_mode ? edge_flag_q : ~sync_q[TOP];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_flag,
  input  logic [NUM_TMR-1:0] tmr_ovf,
  input  logic [NUM_TMR-1:0] tmr_clr,
  input  logic               ser_rx,
  input  logic               ser_tx,
  input  logic               t2_ovf,
  input  logic               t2_ext,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_TMR-1:0] tmr_q;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmr_q[t] <= 1'b0;
      else if (tmr_ovf[t]) tmr_q[t] <= 1'b1;
      else if (tmr_clr[t]) tmr_q[t] <= 1'b0;
    end
  end

  always_comb begin
    pend           = '0;
    pend[SRC_EXT0] = ext_flag[0];
    pend[SRC_TMR0] = tmr_q[0];
    pend[SRC_EXT1] = ext_flag[1];
    pend[SRC_TMR1] = tmr_q[1];
    pend[SRC_SER]  = ser_rx | ser_tx;
    pend[SRC_TMR2] = t2_ovf | t2_ext;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_ctl_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en_src,
  input  logic               en_glb,
  input  logic [NUM_SRC-1:0] pri_hi,
  input  logic [1:0]         insvc,
  output logic [NUM_SRC-1:0] elig,
  output pick_t              win
);
  logic [NUM_SRC-1:0] armed, hi_ok, lo_ok;
  pick_t hi_pick, lo_pick;

  assign armed = pend & en_src & {NUM_SRC{en_glb}};

  // insvc[1]: high level busy, insvc[0]: low level busy
  assign hi_ok = insvc[1] ? '0 : (armed & pri_hi);
  assign lo_ok = (insvc[1] | insvc[0]) ? '0 : (armed & ~pri_hi);
  assign elig  = hi_ok | lo_ok;

  assign hi_pick = first_set(hi_ok);
  assign lo_pick = first_set(lo_ok);
  assign win     = hi_pick.vld ? hi_pick : lo_pick;
endmodule

// File: rtl/irq_ctl_2lvl.sv
module irq_ctl_2lvl
  import irq_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [7:0]         reg_wdata,
  input  logic               ext0_n,
  input  logic               ext1_n,
  input  logic [1:0]         ext_edge_mode,
  input  logic               tmr0_ovf,
  input  logic               tmr1_ovf,
  input  logic               ser_rx_flag,
  input  logic               ser_tx_flag,
  input  logic               tmr2_ovf_flag,
  input  logic               tmr2_ext_flag,
  input  logic               insn_bound,
  input  logic               reti,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               irq_ack,
  output logic [NUM_SRC-1:0] flag_pend
);
  logic                 en_glb_q;
  logic [NUM_SRC-1:0]   en_src_q;
  logic [NUM_SRC-1:0]   pri_q;
  logic [1:0]           insvc_q;
  logic                 hold_vld_q;
  logic [SRC_IDX_W-1:0] hold_idx_q;
  logic                 ack_q;
  logic [SRC_IDX_W-1:0] ack_idx_q;

  logic [NUM_EXT-1:0]   ext_pin_n, ext_flag, ext_fall, ext_clr;
  logic [NUM_HWCLR-1:0] hw_clr;
  logic [NUM_SRC-1:0]   pend, elig;
  pick_t                win;
  logic                 held_ok, accept, withdraw;
  logic                 unused_wdata;

  assign unused_wdata = reg_wdata[6];
  assign ext_pin_n    = {ext1_n, ext0_n};

  // acknowledge clears only the hardware-cleared sources (indices 0..3)
  for (genvar c = 0; c < NUM_HWCLR; c++) begin : g_clr
    assign hw_clr[c] = ack_q && (ack_idx_q == SRC_IDX_W'(c));
  end
  assign ext_clr = {hw_clr[SRC_EXT1], hw_clr[SRC_EXT0]};

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    irq_ext_in #(.SYNC_STAGES(2)) u_ext (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n    (ext_pin_n[e]),
      .edge_mode(ext_edge_mode[e]),
      .clr      (ext_clr[e]),
      .flag     (ext_flag[e]),
      .fall_evt (ext_fall[e])
    );
  end

  irq_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_flag(ext_flag),
    .tmr_ovf ({tmr1_ovf, tmr0_ovf}),
    .tmr_clr ({hw_clr[SRC_TMR1], hw_clr[SRC_TMR0]}),
    .ser_rx  (ser_rx_flag),
    .ser_tx  (ser_tx_flag),
    .t2_ovf  (tmr2_ovf_flag),
    .t2_ext  (tmr2_ext_flag),
    .pend    (pend)
  );

  irq_pick u_pick (
    .pend  (pend),
    .en_src(en_src_q),
    .en_glb(en_glb_q),
    .pri_hi(pri_q),
    .insvc (insvc_q),
    .elig  (elig),
    .win   (win)
  );

  assign held_ok  = hold_vld_q && elig[hold_idx_q];
  assign withdraw = hold_vld_q && !elig[hold_idx_q];
  assign accept   = held_ok && insn_bound;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_glb_q <= 1'b0;
      en_src_q <= '0;
      pri_q    <= '0;
    end else if (reg_wr) begin
      if (!reg_sel) begin
        en_glb_q <= reg_wdata[7];
        en_src_q <= reg_wdata[NUM_SRC-1:0];
      end else begin
        pri_q <= reg_wdata[NUM_SRC-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
      hold_idx_q <= '0;
    end else if (accept || withdraw) begin
      hold_vld_q <= 1'b0;
    end else if (!hold_vld_q && !ack_q && win.vld) begin
      hold_vld_q <= 1'b1;
      hold_idx_q <= win.idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q     <= 1'b0;
      ack_idx_q <= '0;
    end else begin
      ack_q <= accept;
      if (accept) ack_idx_q <= hold_idx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insvc_q <= 2'b00;
    end else begin
      logic [1:0] nxt;
      nxt = insvc_q;
      if (reti) begin
        if (nxt[1]) nxt[1] = 1'b0;
        else        nxt[0] = 1'b0;
      end
      if (accept) begin
        if (pri_q[hold_idx_q]) nxt[1] = 1'b1;
        else                   nxt[0] = 1'b1;
      end
      insvc_q <= nxt;
    end
  end

  assign irq_req   = held_ok;
  assign irq_vec   = held_ok ? vec_of(hold_idx_q) : '0;
  assign irq_ack   = ack_q;
  assign flag_pend = pend;
endmodule

// File: rtl/irq_ctl_2lvl_chk.sv
module irq_ctl_2lvl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_req,
  input logic        irq_ack,
  input logic [15:0] irq_vec,
  input logic        reti,
  input logic [1:0]  insvc,
  input logic        en_glb
);
  assert_idle_vec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vec == 16'h0000);

  assert_global_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> en_glb);

  assert_vec_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec < 16'h0030));

  assert_high_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    insvc[1] |-> !irq_req);

  assert_reti_high_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && insvc == 2'b11) |=> insvc == 2'b01);

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  assert_ack_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !irq_req);

  assert_vec_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> (!irq_req || $stable(irq_vec)));
endmodule

bind irq_ctl_2lvl irq_ctl_2lvl_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq_req(irq_req),
  .irq_ack(irq_ack),
  .irq_vec(irq_vec),
  .reti   (reti),
  .insvc  (insvc_q),
  .en_glb (en_glb_q)
);

// File: tb/irq_ctl_2lvl_test.sv
`timescale 1ns/1ps
module irq_ctl_2lvl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic        ext0_n = 1'b1, ext1_n = 1'b1;
  logic [1:0]  ext_edge_mode = 2'b00;
  logic        tmr0_ovf = 1'b0, tmr1_ovf = 1'b0;
  logic        ser_rx_flag = 1'b0, ser_tx_flag = 1'b0;
  logic        tmr2_ovf_flag = 1'b0, tmr2_ext_flag = 1'b0;
  logic        insn_bound = 1'b0, reti = 1'b0;
  logic        irq_req, irq_ack;
  logic [15:0] irq_vec;
  logic [5:0]  flag_pend;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_ctl_2lvl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ext0_n(ext0_n), .ext1_n(ext1_n),
    .ext_edge_mode(ext_edge_mode), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
    .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
    .tmr2_ovf_flag(tmr2_ovf_flag), .tmr2_ext_flag(tmr2_ext_flag),
    .insn_bound(insn_bound), .reti(reti), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack), .flag_pend(flag_pend)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_t0();
    tmr0_ovf = 1'b1; @(negedge clk); tmr0_ovf = 1'b0;
  endtask

  task automatic pulse_t1();
    tmr1_ovf = 1'b1; @(negedge clk); tmr1_ovf = 1'b0;
  endtask

  task automatic take(input string tag);
    insn_bound = 1'b1; @(negedge clk); insn_bound = 1'b0;
    chk({tag, " ack"}, {31'd0, irq_ack}, 32'd1);
    chk({tag, " req low in ack"}, {31'd0, irq_req}, 32'd0);
  endtask

  task automatic ret();
    reti = 1'b1; @(negedge clk); reti = 1'b0;
  endtask

  // vector table restated as a lookup, not a formula
  function automatic logic [15:0] exp_vec(input int idx);
    case (idx)
      0: return 16'h0003;
      1: return 16'h000B;
      2: return 16'h0013;
      3: return 16'h001B;
      4: return 16'h0023;
      default: return 16'h002B;
    endcase
  endfunction

  function automatic int exp_win(input logic [5:0] m, input logic [5:0] p);
    logic [5:0] grp;
    grp = ((m & p) != 6'd0) ? (m & p) : m;
    for (int i = 0; i < 6; i++) if (grp[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] pri_set [5];
    pri_set[0] = 8'h00; pri_set[1] = 8'h3F; pri_set[2] = 8'h15;
    pri_set[3] = 8'h2A; pri_set[4] = 8'h24;

    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 req after reset", {31'd0, irq_req}, 32'd0);
    chk("R1 ack after reset", {31'd0, irq_ack}, 32'd0);
    chk("R1 vec after reset", {16'd0, irq_vec}, 32'h0);
    chk("R1 flags after reset", {26'd0, flag_pend}, 32'h0);

    // enable gating and flag visibility
    pulse_t0(); cyc(3);
    chk("R10 flag visible while disabled", {26'd0, flag_pend}, 32'h02);
    chk("R2 no req while disabled", {31'd0, irq_req}, 32'd0);
    wr(0, 8'h02); cyc(3);
    chk("R2 source bit alone", {31'd0, irq_req}, 32'd0);
    wr(0, 8'h80); cyc(3);
    chk("R2 global bit alone", {31'd0, irq_req}, 32'd0);
    wr(0, 8'h42); cyc(3);
    chk("R2 bit6 is no global", {31'd0, irq_req}, 32'd0);
    wr(0, 8'h82); cyc(2);
    chk("R2 both bits req", {31'd0, irq_req}, 32'd1);
    chk("R5 timer0 vector", {16'd0, irq_vec}, 32'h000B);
    take("R8 timer0");
    cyc(1);
    chk("R8 ack one cycle", {31'd0, irq_ack}, 32'd0);
    chk("R9 timer0 flag cleared", {31'd0, flag_pend[1]}, 32'd0);
    ret(); cyc(2);
    chk("R9 no rerequest", {31'd0, irq_req}, 32'd0);

    // exhaustive sweep over pending sets under several priority masks
    for (int pi = 0; pi < 5; pi++) begin
      for (int mi = 1; mi < 64; mi++) begin
        logic [5:0] m;
        int w;
        m = mi[5:0];
        wr(1, pri_set[pi]);
        wr(0, 8'h3F);
        ext0_n = ~m[0]; ext1_n = ~m[2]; ser_rx_flag = m[4]; tmr2_ovf_flag = m[5];
        if (m[1]) pulse_t0();
        if (m[3]) pulse_t1();
        cyc(4);
        chk("R10 sweep flags", {26'd0, flag_pend}, {26'd0, m});
        chk("R2 sweep no global", {31'd0, irq_req}, 32'd0);
        wr(0, 8'hBF); cyc(2);
        w = exp_win(m, pri_set[pi][5:0]);
        chk("R3 R4 sweep req", {31'd0, irq_req}, 32'd1);
        chk("R3 R4 R5 sweep winner", {16'd0, irq_vec}, {16'd0, exp_vec(w)});
        ext0_n = 1'b1; ext1_n = 1'b1; ser_rx_flag = 1'b0; tmr2_ovf_flag = 1'b0;
        cyc(4);
        for (int k = 0; k < 4; k++) begin
          if (irq_req) begin
            take("R8 sweep drain");
            cyc(1); ret(); cyc(2);
          end else begin
            cyc(1);
          end
        end
        chk("R9 sweep timers cleared", {26'd0, flag_pend}, 32'h0);
        chk("R9 sweep idle", {31'd0, irq_req}, 32'd0);
      end
    end

    // nesting: timer0 high, timer1 low
    wr(1, 8'h02); wr(0, 8'h8A);
    pulse_t1(); cyc(3);
    chk("R5 timer1 vector", {16'd0, irq_vec}, 32'h001B);
    take("R8 low accept"); cyc(1);
    chk("R9 timer1 flag cleared", {31'd0, flag_pend[3]}, 32'd0);
    pulse_t1(); cyc(3);
    chk("R6 low blocked by low", {31'd0, irq_req}, 32'd0);
    chk("R10 timer1 still pending", {31'd0, flag_pend[3]}, 32'd1);
    pulse_t0(); cyc(3);
    chk("R6 high preempts low", {31'd0, irq_req}, 32'd1);
    chk("R6 preempt vector", {16'd0, irq_vec}, 32'h000B);
    take("R8 high accept"); cyc(1);
    pulse_t0(); cyc(3);
    chk("R6 high blocks all", {31'd0, irq_req}, 32'd0);
    ret(); cyc(2);
    chk("R7 high released first", {31'd0, irq_req}, 32'd1);
    chk("R7 high vector", {16'd0, irq_vec}, 32'h000B);
    take("R8 second high"); cyc(1);
    ret(); cyc(2);
    chk("R7 low still busy", {31'd0, irq_req}, 32'd0);
    ret(); cyc(2);
    chk("R7 low released", {31'd0, irq_req}, 32'd1);
    chk("R7 low vector", {16'd0, irq_vec}, 32'h001B);
    take("R8 low again"); cyc(1); ret(); cyc(2);
    chk("R7 all idle", {31'd0, irq_req}, 32'd0);

    // held vector stability and withdrawal
    wr(1, 8'h00); wr(0, 8'h8A);
    pulse_t1(); cyc(3);
    chk("R12 held timer1", {16'd0, irq_vec}, 32'h001B);
    pulse_t0(); cyc(3);
    chk("R12 vector kept", {16'd0, irq_vec}, 32'h001B);
    wr(0, 8'h0A);
    chk("R2 global off drops req", {31'd0, irq_req}, 32'd0);
    wr(0, 8'h8A); cyc(2);
    chk("R3 timer0 polls first", {16'd0, irq_vec}, 32'h000B);
    take("R8 t0"); cyc(1); ret(); cyc(2);
    chk("R3 timer1 next", {16'd0, irq_vec}, 32'h001B);
    take("R8 t1"); cyc(1); ret(); cyc(2);
    chk("R3 done", {31'd0, irq_req}, 32'd0);

    // software-cleared sources
    wr(0, 8'h90);
    ser_rx_flag = 1'b1; cyc(2);
    chk("R5 serial vector", {16'd0, irq_vec}, 32'h0023);
    take("R8 serial"); cyc(1);
    chk("R9 serial flag kept", {31'd0, flag_pend[4]}, 32'd1);
    ret(); cyc(2);
    chk("R9 serial requests again", {16'd0, irq_vec}, 32'h0023);
    ser_rx_flag = 1'b0; ser_tx_flag = 1'b1; cyc(2);
    chk("R5 serial tx vector", {16'd0, irq_vec}, 32'h0023);
    ser_tx_flag = 1'b0; cyc(2);
    chk("R9 serial idle", {31'd0, irq_req}, 32'd0);
    wr(0, 8'hA0);
    tmr2_ext_flag = 1'b1; cyc(2);
    chk("R5 timer2 vector", {16'd0, irq_vec}, 32'h002B);
    take("R8 timer2"); cyc(1);
    chk("R9 timer2 flag kept", {31'd0, flag_pend[5]}, 32'd1);
    tmr2_ext_flag = 1'b0; ret(); cyc(2);
    chk("R9 timer2 idle", {31'd0, irq_req}, 32'd0);

    // falling-edge mode on external 0
    ext_edge_mode = 2'b01; wr(0, 8'h81);
    ext0_n = 1'b0;
    cyc(2);
    chk("R11 flag not yet", {31'd0, flag_pend[0]}, 32'd0);
    cyc(1);
    chk("R11 flag after three edges", {31'd0, flag_pend[0]}, 32'd1);
    cyc(1);
    chk("R5 ext0 vector", {16'd0, irq_vec}, 32'h0003);
    take("R8 ext0"); cyc(1);
    chk("R9 ext0 edge flag cleared", {31'd0, flag_pend[0]}, 32'd0);
    ret(); cyc(3);
    chk("R11 held low no retrigger", {31'd0, irq_req}, 32'd0);
    ext0_n = 1'b1; cyc(4);
    chk("R11 rising edge no flag", {26'd0, flag_pend}, 32'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule